// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

The block splits a total element count into a series of vector operations, none longer than the maximum vector length `MVL`. After a start pulse it hands out one strip at a time over a valid/ready handshake. Each strip has a start index and a length. While the strip is presented, a vector length register output holds that same length so that a vector datapath can read it.

`MVL` is a power of two, so the remainder and the quotient of the count come from slicing bits of `n_i`; the block has no divider. The odd-sized piece is issued first, at index 0, and every strip after it is a full `MVL`. When the remainder is zero, that empty first strip is dropped. A count of zero produces no strips and finishes at once. A `done_o` pulse marks the end of each run, and a new start is ignored until the current run is over.

Top module: `strip_seq`

## Requirements
- R1: After a start with count n > 0 and n mod MVL ≠ 0, the first strip starts at index 0 and has length n mod MVL, which is the low log2(MVL) bits of n. MVL defaults to 64.
- R2: Every strip after the first, and the first strip as well when n mod MVL = 0, has length exactly MVL.
- R3: The start index of each strip equals the previous strip's start index plus the previous strip's length.
- R4: A run issues floor(n/MVL)+1 strips when n mod MVL ≠ 0 and floor(n/MVL) strips when it is 0, so a zero-length strip is never made valid.
- R5: A start with n = 0 makes no strip valid, and `done_o` is high for one cycle, in the cycle right after the start edge.
- R6: `strip_last_o` is 1 on the final strip of a run and 0 on every other strip. After the final strip is accepted, `strip_valid_o` is low and `done_o` pulses for one cycle.
- R7: A strip changes only on a cycle where valid and ready are both high. While valid is high and ready is low, the index, length and last flag stay unchanged.
- R8: While `strip_valid_o` is high, `vlr_o` equals `strip_len_o`.
- R9: `start_i` has no effect while a run is in progress (`busy_o` high).
- R10: During reset and after it, `strip_valid_o`, `busy_o` and `done_o` are 0 and `vlr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only when idle |
| n_i | input | N_W | Total element count |
| strip_ready_i | input | 1 | Consumer accepts the current strip |
| strip_valid_o | output | 1 | A strip is presented |
| strip_start_o | output | N_W | First element index of the strip |
| strip_len_o | output | $clog2(MVL)+1 | Strip length, 1..MVL |
| strip_last_o | output | 1 | Final strip of the run |
| vlr_o | output | $clog2(MVL)+1 | Vector length register |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench covers four corner cases:
- Counts that are exact multiples of MVL. A design that does not skip the empty remainder strip would present a zero-length strip, or one strip too many.
- A count of zero. A wrong design would either hang or emit a strip.
- Counts below MVL. A wrong design would drop the last flag or issue a spurious full strip.
- Random backpressure and a second start during a run. These expose strips that move without a handshake, and a run that is restarted or corrupted by the ignored pulse.

// File: rtl/strip_pkg.sv
package strip_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_ISSUE = 1'b1} seq_state_e;
endpackage

// File: rtl/strip_split.sv
// Count decomposition by bit slicing (MVL is a power of two)
module strip_split #(
  parameter int N_W = 16,
  parameter int MVL = 64,
  localparam int SH    = $clog2(MVL),
  localparam int LEN_W = SH + 1,
  localparam int CNT_W = N_W - SH
) (
  input  logic [N_W-1:0]   n_i,
  output logic [LEN_W-1:0] rem_len_o,
  output logic [CNT_W-1:0] full_cnt_o,
  output logic             rem_zero_o,
  output logic             n_zero_o
);
  assign rem_len_o  = {1'b0, n_i[SH-1:0]};
  assign full_cnt_o = n_i[N_W-1:SH];
  assign rem_zero_o = (n_i[SH-1:0] == '0);
  assign n_zero_o   = (n_i == '0);
endmodule

// File: rtl/strip_cursor.sv
// Strip index, length and remaining full-strip count
module strip_cursor #(
  parameter int N_W = 16,
  parameter int MVL = 64,
  localparam int SH    = $clog2(MVL),
  localparam int LEN_W = SH + 1,
  localparam int CNT_W = N_W - SH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] rem_len_i,
  input  logic [CNT_W-1:0] full_cnt_i,
  input  logic             rem_zero_i,
  output logic [N_W-1:0]   start_o,
  output logic [LEN_W-1:0] len_o,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] MVL_LEN = LEN_W'(MVL);

  logic [N_W-1:0]   start_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      len_q   <= '0;
      left_q  <= '0;
    end else if (load_i) begin
      start_q <= '0;
      if (rem_zero_i) begin
        // empty remainder strip is skipped
        len_q  <= MVL_LEN;
        left_q <= full_cnt_i - CNT_W'(1);
      end else begin
        len_q  <= rem_len_i;
        left_q <= full_cnt_i;
      end
    end else if (adv_i && (left_q != '0)) begin
      start_q <= start_q + N_W'(len_q);
      len_q   <= MVL_LEN;
      left_q  <= left_q - CNT_W'(1);
    end
  end

  assign start_o = start_q;
  assign len_o   = len_q;
  assign last_o  = (left_q == '0);
endmodule

// File: rtl/strip_fsm.sv
module strip_fsm
  import strip_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic n_zero_i,
  input  logic fire_i,
  input  logic last_i,
  output logic busy_o,
  output logic load_o,
  output logic adv_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    adv_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (n_zero_i) begin
            done_d = 1'b1;
          end else begin
            load_o  = 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (fire_i) begin
          adv_o = 1'b1;
          if (last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == ST_ISSUE);
  assign done_o = done_q;
endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int N_W = 16,
  parameter int MVL = 64,
  localparam int SH    = $clog2(MVL),
  localparam int LEN_W = SH + 1,
  localparam int CNT_W = N_W - SH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_W-1:0]   n_i,
  input  logic             strip_ready_i,
  output logic             strip_valid_o,
  output logic [N_W-1:0]   strip_start_o,
  output logic [LEN_W-1:0] strip_len_o,
  output logic             strip_last_o,
  output logic [LEN_W-1:0] vlr_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [LEN_W-1:0] rem_len;
  logic [CNT_W-1:0] full_cnt;
  logic             rem_zero, n_zero;
  logic             load, adv, fire, last, busy;

  strip_split #(.N_W(N_W), .MVL(MVL)) u_split (
    .n_i       (n_i),
    .rem_len_o (rem_len),
    .full_cnt_o(full_cnt),
    .rem_zero_o(rem_zero),
    .n_zero_o  (n_zero)
  );

  strip_cursor #(.N_W(N_W), .MVL(MVL)) u_cursor (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .adv_i     (adv),
    .rem_len_i (rem_len),
    .full_cnt_i(full_cnt),
    .rem_zero_i(rem_zero),
    .start_o   (strip_start_o),
    .len_o     (strip_len_o),
    .last_o    (last)
  );

  strip_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .n_zero_i(n_zero),
    .fire_i  (fire),
    .last_i  (last),
    .busy_o  (busy),
    .load_o  (load),
    .adv_o   (adv),
    .done_o  (done_o)
  );

  assign fire          = busy & strip_ready_i;
  assign strip_valid_o = busy;
  assign strip_last_o  = busy & last;
  assign busy_o        = busy;
  // length register read by the datapath
  assign vlr_o         = strip_len_o;
endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
  parameter int N_W = 16,
  parameter int MVL = 64,
  localparam int LEN_W = $clog2(MVL) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             strip_ready_i,
  input logic             strip_valid_o,
  input logic [N_W-1:0]   strip_start_o,
  input logic [LEN_W-1:0] strip_len_o,
  input logic             strip_last_o,
  input logic [LEN_W-1:0] vlr_o,
  input logic             busy_o,
  input logic             done_o
);
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_valid_o |-> (strip_len_o != '0) && (strip_len_o <= LEN_W'(MVL))); // R4
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_valid_o && !strip_ready_i |=> strip_valid_o && $stable(strip_start_o)
      && $stable(strip_len_o) && $stable(strip_last_o)); // R7
  AST_NEXT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_valid_o && strip_ready_i && !strip_last_o |=> strip_valid_o
      && (strip_len_o == LEN_W'(MVL))); // R2
  AST_NEXT_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_valid_o && strip_ready_i && !strip_last_o |=>
      strip_start_o == $past(strip_start_o) + N_W'($past(strip_len_o))); // R3
  AST_END_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_valid_o && strip_ready_i && strip_last_o |=> !strip_valid_o && done_o); // R6
  AST_VLR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_valid_o |-> vlr_o == strip_len_o); // R8
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !(strip_ready_i && strip_last_o) |=> busy_o); // R9
endmodule

bind strip_seq strip_seq_chk #(.N_W(N_W), .MVL(MVL)) u_chk (.*);

// File: tb/tb_strip_seq.sv
module tb_strip_seq;
  localparam int N_W = 16;
  localparam int MVL = 64;
  localparam int LEN_W = $clog2(MVL) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [N_W-1:0]   n = '0;
  logic             ready = 1'b0;
  logic             valid, last, busy, done;
  logic [N_W-1:0]   s_start;
  logic [LEN_W-1:0] s_len, vlr;

  int checks = 0, errors = 0;
  int q_start[$], q_len[$], q_last[$];
  int done_cnt = 0;
  int rmode = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  strip_seq #(.N_W(N_W), .MVL(MVL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_i(n),
    .strip_ready_i(ready), .strip_valid_o(valid), .strip_start_o(s_start),
    .strip_len_o(s_len), .strip_last_o(last), .vlr_o(vlr),
    .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ready pattern changes just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ready = (rmode == 0) ? 1'b1 : lfsr[0];
  end

  // monitor: pop and compare each accepted strip
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (valid) check(vlr == s_len, "R8 vlr", int'(vlr), int'(s_len));
      if (valid && ready) begin
        if (q_start.size() == 0) begin
          check(1'b0, "R4 extra strip", int'(s_len), 0);
        end else begin
          int es, el, ex;
          es = q_start.pop_front(); el = q_len.pop_front(); ex = q_last.pop_front();
          check(int'(s_start) == es, "R3 start index", int'(s_start), es);
          check(int'(s_len) == el, (es == 0) ? "R1 first len" : "R2 full len", int'(s_len), el);
          check(int'(last) == ex, "R6 last flag", int'(last), ex);
        end
      end
    end
  end

  task automatic run(input int cnt, input int mode);
    int rem, full, idx, dc;
    rmode = mode;
    rem = cnt % MVL; full = cnt / MVL; idx = 0;
    if (rem != 0) begin
      q_start.push_back(0); q_len.push_back(rem); q_last.push_back(full == 0);
      idx = rem;
    end
    for (int k = 0; k < full; k++) begin
      q_start.push_back(idx); q_len.push_back(MVL); q_last.push_back(k == full - 1);
      idx += MVL;
    end
    dc = done_cnt;
    @(negedge clk); n = N_W'(cnt); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (cnt == 0) begin
      check(done == 1'b1, "R5 done at once", int'(done), 1);
      check(valid == 1'b0, "R5 no strip", int'(valid), 0);
    end
    while (busy) begin
      @(negedge clk);
      // second start mid-run must be ignored
      if (cnt > 3 * MVL && q_start.size() == 2) begin start = 1'b1; n = N_W'(7); end
      else start = 1'b0;
    end
    start = 1'b0;
    @(negedge clk);
    check(q_start.size() == 0, "R4 strip count", q_start.size(), 0);
    check(done_cnt == dc + 1, "R6 done pulse", done_cnt - dc, 1);
    check(valid == 1'b0, "R9 idle after run", int'(valid), 0);
    q_start.delete(); q_len.delete(); q_last.delete();
  endtask

  initial begin
    #1;
    check(valid == 0 && busy == 0 && done == 0 && vlr == 0, "R10 reset", int'(valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid == 0 && busy == 0 && done == 0 && vlr == 0, "R10 after reset", int'(vlr), 0);
    run(0, 0);
    run(5, 0);
    run(1, 1);
    run(64, 0);
    run(128, 1);
    run(130, 0);
    run(63, 1);
    run(300, 1);
    run(0, 1);
    run(513, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 50000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule